// File: doc/BRIEF.md
# Buffered Serial Line Transmitter

This block turns words written by a host into asynchronous serial frames on one output line. A word written while the line is busy waits in a one-entry holding register. When the current frame finishes, the holding register feeds the shift stage with no gap on the line. Each frame has a low start bit, then the data slots least significant first, then a high stop period of one, one and a half or two bit times. When parity is on, the last data slot carries the parity bit.

Bit timing comes from a programmable clock divisor followed by a fixed oversampling factor of 16 ticks per bit. That makes a one-and-a-half stop period exactly 24 ticks long. Whenever the transmitter goes from disabled to enabled, it first sends an idle frame: the line stays high for one full frame length. Only after that does any data go out.

Two flags are brought out:
- The holding-empty flag shows when the next word may be written.
- The transmission-complete flag shows that the line has gone quiet.

Each flag has its own interrupt enable, and the two enabled flags together drive the interrupt output. A synchronous clock output can also be turned on. It pulses once per data slot, and a control bit decides whether the last slot gets a pulse.

Top module: `uart_tx_core`

## Requirements
- R1: After reset `txd` is 1, `hold_empty` is 1, `tx_done` is 1, `sclk` is 0, and `irq` is 0 while both interrupt enables are 0.
- R2: A frame is a start bit at 0, then the data slots from bit 0 upward, then a stop period at 1. Each bit lasts 16 × `cfg_div` clock cycles.
- R3: The `cfg_wlen` field sets the slot count: 2'b00 gives 8 slots, 2'b01 gives 9 slots and 2'b10 gives 7 slots. Written bits above the slot count are not sent.
- R4: With `cfg_par_en` = 1 the last slot carries parity over the slots below it. With `cfg_par_odd` = 0 the total number of ones across data and parity is even; with `cfg_par_odd` = 1 it is odd.
- R5: The `cfg_stop` field sets the stop period: 2'b00 gives 16 ticks, 2'b01 gives 24 ticks and 2'b10 gives 32 ticks. Back-to-back frames therefore start exactly 16 × (1 + slots) + stop ticks apart.
- R6: When `cfg_ue & cfg_te` rises, the engine sends one idle frame first. The line stays high for a full frame length, and the frame starts two clocks after the enabling value is applied. Queued data follows without a gap.
- R7: A write makes `hold_empty` 0 on the next cycle. A write made during a frame is held, and it starts the moment the current frame ends. `hold_empty` returns to 1 in the cycle that frame starts.
- R8: `tx_done` goes to 0 on a write or when any frame starts. It goes to 1 when a frame's stop period ends with no data or idle frame waiting.
- R9: `irq` is 1 exactly when (`hold_empty` and `cfg_empty_ie`) or (`tx_done` and `cfg_done_ie`).
- R10: With `cfg_sclk_en` = 1, `sclk` is high in the second half of each data slot of a data frame. It gives no pulse for start, stop or idle frames. The last slot pulses only if `cfg_sclk_last` = 1. With `cfg_sclk_en` = 0, `sclk` stays 0.
- R11: The line is 1 whenever no frame is being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_div | input | DIV_W | Clock cycles per oversampling tick (0 is treated as 1) |
| cfg_wlen | input | 2 | Slot count select |
| cfg_stop | input | 2 | Stop period select |
| cfg_par_en | input | 1 | Parity in last slot |
| cfg_par_odd | input | 1 | Odd parity when 1 |
| cfg_ue | input | 1 | Block enable |
| cfg_te | input | 1 | Transmit enable |
| cfg_empty_ie | input | 1 | Interrupt enable for holding-empty |
| cfg_done_ie | input | 1 | Interrupt enable for transmission-complete |
| cfg_sclk_en | input | 1 | Synchronous clock output enable |
| cfg_sclk_last | input | 1 | Pulse for last data slot |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 9 | Word to send |
| txd | output | 1 | Serial line |
| sclk | output | 1 | Synchronous clock output |
| hold_empty | output | 1 | Holding register may be written |
| tx_done | output | 1 | Line quiet, nothing waiting |
| irq | output | 1 | Combined interrupt |

## Verification
The bench measures exact cycle distances between start-bit edges:
- A design that leaves a dead cycle between queued frames, or rounds the 1.5 stop period to one or two bits, lands off the expected distance.
- An engine that skips the idle frame after enabling shows up as an early first start edge, at the wrong cycle count.

Frames are decoded at mid-bit for all three slot counts, and for both parity senses with parity in the last slot. A swapped parity sense or a shifted slot order therefore produces a wrong word.

The flag sequence around a write made during a frame is sampled cycle by cycle. This catches a complete flag that rises while data still waits, and a holding-empty flag that rises too early. The bench also counts clock pulses per frame, which catches a last-slot pulse control with the wrong sense.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    localparam int MAX_SLOTS = 9;

    typedef enum logic [1:0] {
        WLEN_8  = 2'b00,
        WLEN_9  = 2'b01,
        WLEN_7  = 2'b10,
        WLEN_8X = 2'b11
    } wlen_e;

    typedef enum logic [1:0] {
        STOP_1  = 2'b00,
        STOP_1H = 2'b01,
        STOP_2  = 2'b10,
        STOP_2X = 2'b11
    } stop_e;

    typedef struct packed {
        wlen_e wlen;
        stop_e stop;
        logic  par_en;
        logic  par_odd;
        logic  sclk_en;
        logic  sclk_last;
    } line_cfg_t;

    // number of data slots in a frame (parity included)
    function automatic int slot_count(wlen_e w);
        case (w)
            WLEN_9:  return 9;
            WLEN_7:  return 7;
            default: return 8;
        endcase
    endfunction

    // stop period in half-bit units
    function automatic int stop_halves(stop_e s);
        case (s)
            STOP_1:  return 2;
            STOP_1H: return 3;
            default: return 4;
        endcase
    endfunction

    // build the slot vector: data masked to the slot count, parity in the top slot
    function automatic logic [MAX_SLOTS-1:0] pack_slots(
        logic [MAX_SLOTS-1:0] d, wlen_e w, logic pe, logic po);
        logic [MAX_SLOTS-1:0] r;
        logic                 p;
        int                   n;
        n = slot_count(w);
        r = '0;
        p = po;
        for (int i = 0; i < MAX_SLOTS; i++) begin
            if (i < n) r[i] = d[i];
            if (i < n - 1) p = p ^ d[i];
        end
        if (pe) begin
            for (int i = 0; i < MAX_SLOTS; i++) begin
                if (i == n - 1) r[i] = p;
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/utx_baud.sv
module utx_baud #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] lim;

    assign lim  = (div == '0) ? '0 : div - 1'b1;
    assign tick = run && (cnt >= lim);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/utx_hold.sv
module utx_hold #(
    parameter int DW = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    input  logic          take,
    input  logic          frame_start,
    input  logic          quiet_end,
    output logic          full,
    output logic [DW-1:0] data,
    output logic          done
);
    always_ff @(posedge clk) begin
        if (rst) begin
            full <= 1'b0;
            data <= '0;
            done <= 1'b1;
        end else begin
            if (wr) data <= wdata;
            full <= wr | (full & ~take);
            if (wr || frame_start) begin
                done <= 1'b0;
            end else if (quiet_end) begin
                done <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/utx_shift.sv
module utx_shift
    import uart_tx_pkg::*;
#(
    parameter int OVS   = 16,
    parameter int CNT_W = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick,
    input  logic                 go,
    input  logic                 idle_req,
    input  logic                 hold_full,
    input  logic [MAX_SLOTS-1:0] hold_data,
    input  line_cfg_t            cfg,
    output logic                 busy,
    output logic                 take,
    output logic                 idle_ack,
    output logic                 frame_start,
    output logic                 quiet_end,
    output logic                 txd,
    output logic                 sclk
);
    logic [CNT_W-1:0]     ftk;
    logic [CNT_W-1:0]     last_tk;
    logic [MAX_SLOTS-1:0] slots;
    logic [MAX_SLOTS-1:0] shifted;
    logic                 idle_fr;
    logic                 at_end;
    logic                 can_start;
    logic                 start_now;
    logic                 half;
    int                   nd;
    int                   bi;

    always_comb begin
        nd      = slot_count(cfg.wlen);
        last_tk = CNT_W'(OVS * (1 + nd) + (stop_halves(cfg.stop) * OVS) / 2 - 1);
        bi      = int'(ftk) / OVS;
        half    = (int'(ftk) % OVS) >= (OVS / 2);
    end

    assign at_end      = busy && tick && (ftk == last_tk);
    assign can_start   = go && (idle_req || hold_full);
    assign start_now   = (!busy || at_end) && can_start;
    assign take        = start_now && !idle_req;
    assign idle_ack    = start_now && idle_req;
    assign frame_start = start_now;
    assign quiet_end   = at_end && !hold_full && !idle_req;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            ftk     <= '0;
            idle_fr <= 1'b0;
            slots   <= '1;
        end else if (start_now) begin
            busy    <= 1'b1;
            ftk     <= '0;
            idle_fr <= idle_req;
            slots   <= idle_req ? '1 :
                       pack_slots(hold_data, cfg.wlen, cfg.par_en, cfg.par_odd);
        end else if (at_end) begin
            busy    <= 1'b0;
            ftk     <= '0;
            idle_fr <= 1'b0;
        end else if (busy && tick) begin
            ftk <= ftk + 1'b1;
        end
    end

    assign shifted = slots >> ((bi >= 1) ? (bi - 1) : 0);

    always_comb begin
        if (!busy || idle_fr) begin
            txd = 1'b1;
        end else if (bi == 0) begin
            txd = 1'b0;
        end else if (bi <= nd) begin
            txd = shifted[0];
        end else begin
            txd = 1'b1;
        end
    end

    assign sclk = busy && !idle_fr && cfg.sclk_en && (bi >= 1) && (bi <= nd) &&
                  ((bi != nd) || cfg.sclk_last) && half;
endmodule

// File: rtl/uart_tx_core.sv
module uart_tx_core
    import uart_tx_pkg::*;
#(
    parameter int DIV_W = 16,
    parameter int OVS   = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [DIV_W-1:0]     cfg_div,
    input  logic [1:0]           cfg_wlen,
    input  logic [1:0]           cfg_stop,
    input  logic                 cfg_par_en,
    input  logic                 cfg_par_odd,
    input  logic                 cfg_ue,
    input  logic                 cfg_te,
    input  logic                 cfg_empty_ie,
    input  logic                 cfg_done_ie,
    input  logic                 cfg_sclk_en,
    input  logic                 cfg_sclk_last,
    input  logic                 wr_en,
    input  logic [MAX_SLOTS-1:0] wr_data,
    output logic                 txd,
    output logic                 sclk,
    output logic                 hold_empty,
    output logic                 tx_done,
    output logic                 irq
);
    localparam int CNT_W = $clog2(OVS * (MAX_SLOTS + 3) + 1);

    line_cfg_t            cfg;
    logic                 en;
    logic                 en_q;
    logic                 idle_req;
    logic                 tick;
    logic                 busy;
    logic                 take;
    logic                 idle_ack;
    logic                 frame_start;
    logic                 quiet_end;
    logic                 hold_full;
    logic [MAX_SLOTS-1:0] hold_data;

    assign cfg.wlen      = wlen_e'(cfg_wlen);
    assign cfg.stop      = stop_e'(cfg_stop);
    assign cfg.par_en    = cfg_par_en;
    assign cfg.par_odd   = cfg_par_odd;
    assign cfg.sclk_en   = cfg_sclk_en;
    assign cfg.sclk_last = cfg_sclk_last;

    assign en = cfg_ue && cfg_te;

    // an enable edge books one idle frame ahead of any data
    always_ff @(posedge clk) begin
        if (rst) begin
            en_q     <= 1'b0;
            idle_req <= 1'b0;
        end else begin
            en_q <= en;
            if (!en || idle_ack) begin
                idle_req <= 1'b0;
            end else if (!en_q) begin
                idle_req <= 1'b1;
            end
        end
    end

    utx_baud #(.DIV_W(DIV_W)) u_baud (
        .clk  (clk),
        .rst  (rst),
        .run  (busy),
        .div  (cfg_div),
        .tick (tick)
    );

    utx_hold #(.DW(MAX_SLOTS)) u_hold (
        .clk         (clk),
        .rst         (rst),
        .wr          (wr_en),
        .wdata       (wr_data),
        .take        (take),
        .frame_start (frame_start),
        .quiet_end   (quiet_end),
        .full        (hold_full),
        .data        (hold_data),
        .done        (tx_done)
    );

    utx_shift #(.OVS(OVS), .CNT_W(CNT_W)) u_shift (
        .clk         (clk),
        .rst         (rst),
        .tick        (tick),
        .go          (en),
        .idle_req    (idle_req),
        .hold_full   (hold_full),
        .hold_data   (hold_data),
        .cfg         (cfg),
        .busy        (busy),
        .take        (take),
        .idle_ack    (idle_ack),
        .frame_start (frame_start),
        .quiet_end   (quiet_end),
        .txd         (txd),
        .sclk        (sclk)
    );

    assign hold_empty = !hold_full;
    assign irq        = (hold_empty && cfg_empty_ie) || (tx_done && cfg_done_ie);
endmodule

// File: rtl/utx_checker.sv
module utx_checker (
    input logic clk,
    input logic rst,
    input logic txd,
    input logic busy,
    input logic wr_en,
    input logic hold_empty,
    input logic tx_done,
    input logic irq,
    input logic sclk,
    input logic empty_ie,
    input logic done_ie,
    input logic sclk_en
);
    assert_idle_line_R11: assert property (@(posedge clk) disable iff (rst)
        !busy |-> txd);

    assert_start_in_frame_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(txd) |-> busy);

    assert_wr_clears_empty_R7: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !hold_empty);

    assert_empty_on_load_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(hold_empty) |-> busy);

    assert_wr_clears_done_R8: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !tx_done);

    assert_done_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        tx_done |-> !busy);

    assert_irq_empty_R9: assert property (@(posedge clk) disable iff (rst)
        (hold_empty && empty_ie) |-> irq);

    assert_irq_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        ((!hold_empty || !empty_ie) && (!tx_done || !done_ie)) |-> !irq);

    assert_sclk_off_R10: assert property (@(posedge clk) disable iff (rst)
        !sclk_en |-> !sclk);

    assert_sclk_in_frame_R10: assert property (@(posedge clk) disable iff (rst)
        sclk |-> busy);
endmodule

bind uart_tx_core utx_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .txd        (txd),
    .busy       (busy),
    .wr_en      (wr_en),
    .hold_empty (hold_empty),
    .tx_done    (tx_done),
    .irq        (irq),
    .sclk       (sclk),
    .empty_ie   (cfg_empty_ie),
    .done_ie    (cfg_done_ie),
    .sclk_en    (cfg_sclk_en)
);

// File: tb/tb_uart_tx_core.sv
module tb_uart_tx_core;
    localparam int DIVV = 2;
    localparam int BITC = 16 * DIVV;
    localparam int FR8  = 10 * BITC;

    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] cfg_div;
    logic [1:0]  cfg_wlen, cfg_stop;
    logic        cfg_par_en, cfg_par_odd, cfg_ue, cfg_te;
    logic        cfg_empty_ie, cfg_done_ie, cfg_sclk_en, cfg_sclk_last;
    logic        wr_en;
    logic [8:0]  wr_data;
    logic        txd, sclk, hold_empty, tx_done, irq;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int fall_cyc;

    always #10 clk = ~clk;
    always @(posedge clk) cyc++;

    uart_tx_core dut (
        .clk(clk), .rst(rst), .cfg_div(cfg_div), .cfg_wlen(cfg_wlen),
        .cfg_stop(cfg_stop), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .cfg_ue(cfg_ue), .cfg_te(cfg_te), .cfg_empty_ie(cfg_empty_ie),
        .cfg_done_ie(cfg_done_ie), .cfg_sclk_en(cfg_sclk_en),
        .cfg_sclk_last(cfg_sclk_last), .wr_en(wr_en), .wr_data(wr_data),
        .txd(txd), .sclk(sclk), .hold_empty(hold_empty), .tx_done(tx_done),
        .irq(irq)
    );

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_word(logic [8:0] d);
        wr_data = d;
        wr_en   = 1'b1;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic wait_fall();
        while (txd !== 1'b0) @(negedge clk);
        fall_cyc = cyc;
    endtask

    task automatic wait_high();
        while (txd !== 1'b1) @(negedge clk);
    endtask

    task automatic wait_done();
        while (tx_done !== 1'b1) @(negedge clk);
    endtask

    task automatic read_frame(int nd, output logic [8:0] got, output logic st,
                              output logic sp);
        got = '0;
        step(BITC / 2);
        st = txd;
        for (int i = 0; i < nd; i++) begin
            step(BITC);
            got[i] = txd;
        end
        step(BITC);
        sp = txd;
    endtask

    function automatic logic [8:0] expect_slots(logic [8:0] d, int nd, logic pe, logic po);
        logic [8:0] r;
        logic       p;
        r = '0;
        p = po;
        for (int i = 0; i < nd; i++) r[i] = d[i];
        for (int i = 0; i < nd - 1; i++) p = p ^ d[i];
        if (pe) r[nd-1] = p;
        return r;
    endfunction

    task automatic t_reset();
        check("R1", "txd", txd, 1);
        check("R1", "hold_empty", hold_empty, 1);
        check("R1", "tx_done", tx_done, 1);
        check("R1", "sclk", sclk, 0);
        check("R1", "irq", irq, 0);
        check("R11", "line idle", txd, 1);
    endtask

    task automatic t_enable_idle();
        logic [8:0] got;
        logic st, sp;
        int t0;
        cfg_ue = 1'b1;
        cfg_te = 1'b1;
        t0 = cyc;
        write_word(9'h0A5);
        wait_fall();
        check("R6", "idle frame before data", fall_cyc - t0, FR8 + 2);
        read_frame(8, got, st, sp);
        check("R2", "start bit", st, 0);
        check("R2", "data 0xA5", got, 9'h0A5);
        check("R2", "stop bit", sp, 1);
        wait_done();
        check("R11", "line after frame", txd, 1);
    endtask

    task automatic t_reenable();
        int bad = 0;
        cfg_te = 1'b0;
        step(3);
        cfg_te = 1'b1;
        for (int k = 1; k <= FR8 + 2; k++) begin
            @(negedge clk);
            if (txd !== 1'b1) bad++;
            if (k == 1)       check("R8", "done before idle frame", tx_done, 1);
            if (k == 2)       check("R8", "done clears at idle start", tx_done, 0);
            if (k == FR8 + 1) check("R6", "idle frame still running", tx_done, 0);
            if (k == FR8 + 2) check("R6", "idle frame full length", tx_done, 1);
        end
        check("R6", "line high in idle frame", bad, 0);
    endtask

    task automatic t_wlen();
        logic [8:0] got;
        logic st, sp;
        cfg_wlen = 2'b01;
        write_word(9'h1A5);
        wait_fall();
        read_frame(9, got, st, sp);
        check("R3", "9-slot word", got, 9'h1A5);
        check("R3", "9-slot stop", sp, 1);
        wait_done();
        cfg_wlen = 2'b10;
        write_word(9'h1FA);
        wait_fall();
        read_frame(7, got, st, sp);
        check("R3", "7-slot word upper bits dropped", got, 9'h07A);
        check("R3", "7-slot stop after slot 6", sp, 1);
        wait_done();
        cfg_wlen = 2'b00;
    endtask

    task automatic t_parity(logic [1:0] wl, int nd, logic po, logic [8:0] d);
        logic [8:0] got;
        logic st, sp;
        cfg_wlen    = wl;
        cfg_par_en  = 1'b1;
        cfg_par_odd = po;
        write_word(d);
        wait_fall();
        read_frame(nd, got, st, sp);
        check("R4", po ? "odd parity frame" : "even parity frame", got,
              expect_slots(d, nd, 1'b1, po));
        wait_done();
        cfg_par_en = 1'b0;
        cfg_wlen   = 2'b00;
    endtask

    task automatic t_stop(logic [1:0] sc, int stop_ticks);
        int f1;
        cfg_stop = sc;
        write_word(9'h0FF);
        wait_fall();
        f1 = fall_cyc;
        write_word(9'h0FF);
        wait_high();
        wait_fall();
        check("R5", "frame pitch", fall_cyc - f1, (9 * 16 + stop_ticks) * DIVV);
        wait_done();
        cfg_stop = 2'b00;
    endtask

    task automatic t_flags();
        int f1;
        cfg_done_ie  = 1'b0;
        cfg_empty_ie = 1'b0;
        write_word(9'h0FF);
        check("R7", "empty cleared by write", hold_empty, 0);
        check("R8", "done cleared by write", tx_done, 0);
        check("R9", "irq off with enables off", irq, 0);
        step(1);
        check("R7", "empty set at frame start", hold_empty, 1);
        wait_fall();
        f1 = fall_cyc;
        write_word(9'h03C);
        check("R7", "queued write clears empty", hold_empty, 0);
        step(5 * BITC);
        check("R7", "held word waits", hold_empty, 0);
        cfg_empty_ie = 1'b1;
        step(1);
        check("R9", "irq off while full and busy", irq, 0);
        wait_fall();
        check("R7", "queued frame follows with no gap", fall_cyc - f1, FR8);
        check("R7", "empty set when held word starts", hold_empty, 1);
        check("R9", "irq from empty flag", irq, 1);
        check("R8", "done low while second frame runs", tx_done, 0);
        cfg_empty_ie = 1'b0;
        step(FR8 - 1);
        check("R8", "done low in last stop cycle", tx_done, 0);
        step(1);
        check("R8", "done set after stop", tx_done, 1);
        check("R9", "irq off with done_ie off", irq, 0);
        cfg_done_ie = 1'b1;
        step(1);
        check("R9", "irq from done flag", irq, 1);
        cfg_done_ie = 1'b0;
    endtask

    task automatic t_sync(logic en, logic last, int exp);
        int   rises = 0;
        logic prev;
        cfg_sclk_en   = en;
        cfg_sclk_last = last;
        write_word(9'h055);
        wait_fall();
        prev = sclk;
        for (int k = 0; k < FR8; k++) begin
            @(negedge clk);
            if (sclk && !prev) rises++;
            prev = sclk;
        end
        check("R10", "sclk pulses per frame", rises, exp);
        wait_done();
        cfg_sclk_en   = 1'b0;
        cfg_sclk_last = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        rst = 1'b1;
        cfg_div = 16'(DIVV);
        cfg_wlen = 2'b00;
        cfg_stop = 2'b00;
        cfg_par_en = 1'b0;
        cfg_par_odd = 1'b0;
        cfg_ue = 1'b0;
        cfg_te = 1'b0;
        cfg_empty_ie = 1'b0;
        cfg_done_ie = 1'b0;
        cfg_sclk_en = 1'b0;
        cfg_sclk_last = 1'b0;
        wr_en = 1'b0;
        wr_data = '0;
        step(4);
        rst = 1'b0;
        step(1);
        t_reset();
        t_enable_idle();
        t_wlen();
        t_parity(2'b01, 9, 1'b0, 9'h053);
        t_parity(2'b01, 9, 1'b1, 9'h053);
        t_parity(2'b00, 8, 1'b0, 9'h02C);
        t_parity(2'b10, 7, 1'b1, 9'h02C);
        t_stop(2'b00, 16);
        t_stop(2'b01, 24);
        t_stop(2'b10, 32);
        t_flags();
        t_sync(1'b1, 1'b0, 7);
        t_sync(1'b1, 1'b1, 8);
        t_sync(1'b0, 1'b1, 0);
        t_reenable();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule